// File: doc/BRIEF.md
# Token-Ring Spike Address Encoder

This block funnels spike events from a grid of neurons (16 rows by 16 columns by default) onto one shared output channel. The channel carries the row and column index of the neuron being served. There is no priority-encoder tree. Instead, two tokens travel around rings: one visits the rows and one visits the columns. Each token's position register is the address counter for its dimension, so when the column token reaches a waiting neuron, the two counters already hold that neuron's address.

Each neuron raises its request and holds it until it receives a one-cycle acknowledge. The row token moves until it finds a row with at least one request. That row is then granted, and the block takes a snapshot of the row's requests at that moment. The column token walks across the snapshot, and each neuron in it is sent in turn on a valid/ready channel and then acknowledged. When the snapshot is empty, the row is released with one closing cycle, and the row token moves on.

The controller has five states:
- `ST_ROW_HUNT`: the row token steps while any row requests and its current row does not. It holds still when nothing requests. It latches the row's snapshot and goes to `ST_COL_HUNT` when its current row requests.
- `ST_COL_HUNT`: the column token steps until it sits on a snapshot bit, then goes to `ST_SEND`.
- `ST_SEND`: presents the address. On ready it clears that snapshot bit and goes to `ST_ACK`.
- `ST_ACK`: pulses the neuron's acknowledge, then goes back to `ST_COL_HUNT` if snapshot bits remain, otherwise to `ST_FREE`.
- `ST_FREE`: moves the row token one row forward and returns to `ST_ROW_HUNT`.

Top module: `aer_token_encoder`

## Requirements
- R1: After reset, `aer_valid` is 0, every `nrn_ack` bit is 0, and both tokens sit at index 0.
- R2: Neuron (r, c) uses bit r*COLS+c of `nrn_req`/`nrn_ack`. While `aer_valid` is 1, `aer_row` and `aer_col` are r and c of a neuron whose request is still high.
- R3: In `ST_ROW_HUNT` the row token moves one row per clock, in increasing index and wrapping from the last row to 0, while its row has no request and another row does. It does not move when no row requests.
- R4: Take a lone request at (r, c) made while the controller is in `ST_ROW_HUNT`, with the tokens at (pr, pc). `aer_valid` rises after clock edge ((r-pr) mod ROWS) + ((c-pc) mod COLS) + 2, counting the first edge that samples the request as edge 1.
- R5: Within a granted row, neurons are sent in increasing column order, starting at the column token's position and wrapping. After each send the column token stays on the column just served.
- R6: Every neuron requesting in a row when that row is granted is sent before the row token leaves. A request that arrives in the row later waits until the row token comes back around the ring.
- R7: While `aer_valid` is 1 and `aer_ready` is 0, `aer_valid`, `aer_row` and `aer_col` hold steady. Each request is sent exactly once: none is dropped and none is repeated.
- R8: In the cycle after a transfer (`aer_valid` and `aer_ready` both 1 at a clock edge), exactly one `nrn_ack` bit is 1 for one cycle: the bit of the neuron just sent. No ack appears at any other time. The neuron must lower its request before the next clock edge.
- R9: After the last neuron of a granted row is acknowledged, there is one closing cycle, and then the row token stands at row (r+1) mod ROWS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| nrn_req | input | ROWS*COLS | Per-neuron spike request, held until acknowledged |
| nrn_ack | output | ROWS*COLS | Per-neuron one-cycle acknowledge |
| aer_valid | output | 1 | Address on the output channel is valid |
| aer_ready | input | 1 | Downstream accepts the address |
| aer_row | output | clog2(ROWS) | Row index of the neuron being sent |
| aer_col | output | clog2(COLS) | Column index of the neuron being sent |

## Verification
The bench keeps its own model of the two token positions. For a lone request, it expects `aer_valid` on exactly the edge given by R4's formula. The acknowledge is due one edge after the transfer. For a request that joins a row after the grant, the bench expects a full trip around the row ring plus the column distance: valid arrives 20 plus the column distance edges after the previous transfer. Inputs are driven and outputs sampled on the falling edge. Each falling edge is counted as one elapsed rising edge, so every result is compared on the first cycle in which it is due.

// File: rtl/tre_pkg.sv
package tre_pkg;
    typedef enum logic [2:0] {
        ST_ROW_HUNT = 3'd0,
        ST_COL_HUNT = 3'd1,
        ST_SEND     = 3'd2,
        ST_ACK      = 3'd3,
        ST_FREE     = 3'd4
    } tre_state_e;
endpackage

// File: rtl/tre_ring.sv
// Token position on a ring of N stations; the position is also the address counter.
module tre_ring #(
    parameter int N  = 16,
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [N-1:0]  occupied,
    output logic [PW-1:0] pos,
    output logic          hit
);
    localparam logic [PW-1:0] LAST = PW'(N - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (step) begin
            pos <= (pos == LAST) ? '0 : pos + PW'(1);
        end
    end

    assign hit = occupied[pos];
endmodule

// File: rtl/tre_reqmap.sv
// Row-wide request OR and selection of the requests of one row.
module tre_reqmap #(
    parameter int ROWS = 16,
    parameter int COLS = 16,
    parameter int RW   = 4
) (
    input  logic [ROWS*COLS-1:0] req,
    input  logic [RW-1:0]        row_sel,
    output logic [ROWS-1:0]      row_busy,
    output logic [COLS-1:0]      sel_bits
);
    genvar gr;
    generate
        for (gr = 0; gr < ROWS; gr++) begin : g_row_or
            assign row_busy[gr] = |req[gr*COLS +: COLS];
        end
    endgenerate

    always_comb begin
        sel_bits = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (row_sel == RW'(r)) begin
                sel_bits = req[r*COLS +: COLS];
            end
        end
    end
endmodule

// File: rtl/tre_ctrl.sv
// Sequencer: row hunt, column hunt, send, acknowledge, row release.
module tre_ctrl
    import tre_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic row_any,
    input  logic row_hit,
    input  logic col_hit,
    input  logic pend_left,
    input  logic out_ready,
    output logic row_step,
    output logic col_step,
    output logic latch_row,
    output logic retire,
    output logic out_valid,
    output logic ack_on
);
    tre_state_e state, state_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_ROW_HUNT;
        end else begin
            state <= state_n;
        end
    end

    always_comb begin
        state_n = state;
        unique case (state)
            ST_ROW_HUNT: if (row_hit)   state_n = ST_COL_HUNT;
            ST_COL_HUNT: if (col_hit)   state_n = ST_SEND;
            ST_SEND:     if (out_ready) state_n = ST_ACK;
            ST_ACK:      state_n = pend_left ? ST_COL_HUNT : ST_FREE;
            ST_FREE:     state_n = ST_ROW_HUNT;
            default:     state_n = ST_ROW_HUNT;
        endcase
    end

    always_comb begin
        row_step  = 1'b0;
        col_step  = 1'b0;
        latch_row = 1'b0;
        retire    = 1'b0;
        out_valid = 1'b0;
        ack_on    = 1'b0;
        unique case (state)
            ST_ROW_HUNT: begin
                latch_row = row_hit;
                row_step  = row_any && !row_hit;
            end
            ST_COL_HUNT: col_step = !col_hit;
            ST_SEND: begin
                out_valid = 1'b1;
                retire    = out_ready;
            end
            ST_ACK:  ack_on   = 1'b1;
            ST_FREE: row_step = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/aer_token_encoder.sv
module aer_token_encoder #(
    parameter int ROWS = 16,
    parameter int COLS = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ROWS*COLS-1:0]     nrn_req,
    output logic [ROWS*COLS-1:0]     nrn_ack,
    output logic                     aer_valid,
    input  logic                     aer_ready,
    output logic [$clog2(ROWS)-1:0]  aer_row,
    output logic [$clog2(COLS)-1:0]  aer_col
);
    localparam int RW = $clog2(ROWS);
    localparam int CW = $clog2(COLS);
    localparam int NN = ROWS * COLS;

    logic [ROWS-1:0] row_busy;
    logic [COLS-1:0] sel_bits;
    logic [COLS-1:0] pend;
    logic [RW-1:0]   rpos;
    logic [CW-1:0]   cpos;
    logic            row_hit, col_hit;
    logic            row_step, col_step, latch_row, retire, ack_on;

    tre_reqmap #(.ROWS(ROWS), .COLS(COLS), .RW(RW)) u_map (
        .req      (nrn_req),
        .row_sel  (rpos),
        .row_busy (row_busy),
        .sel_bits (sel_bits)
    );

    tre_ring #(.N(ROWS), .PW(RW)) u_row_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (row_step),
        .occupied (row_busy),
        .pos      (rpos),
        .hit      (row_hit)
    );

    tre_ring #(.N(COLS), .PW(CW)) u_col_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (col_step),
        .occupied (pend),
        .pos      (cpos),
        .hit      (col_hit)
    );

    tre_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .row_any   (|row_busy),
        .row_hit   (row_hit),
        .col_hit   (col_hit),
        .pend_left (|pend),
        .out_ready (aer_ready),
        .row_step  (row_step),
        .col_step  (col_step),
        .latch_row (latch_row),
        .retire    (retire),
        .out_valid (aer_valid),
        .ack_on    (ack_on)
    );

    // Snapshot of the granted row; later arrivals wait for the next visit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= '0;
        end else if (latch_row) begin
            pend <= sel_bits;
        end else if (retire) begin
            pend[cpos] <= 1'b0;
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < NN; gi++) begin : g_ack
            assign nrn_ack[gi] = ack_on && (rpos == RW'(gi / COLS))
                                        && (cpos == CW'(gi % COLS));
        end
    endgenerate

    assign aer_row = rpos;
    assign aer_col = cpos;
endmodule

// File: rtl/tre_check.sv
module tre_check #(
    parameter int ROWS = 16,
    parameter int COLS = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [ROWS*COLS-1:0]     nrn_req,
    input logic [ROWS*COLS-1:0]     nrn_ack,
    input logic                     aer_valid,
    input logic                     aer_ready,
    input logic [$clog2(ROWS)-1:0]  aer_row,
    input logic [$clog2(COLS)-1:0]  aer_col
);
    localparam int IW = $clog2(ROWS * COLS);

    logic [IW-1:0] live_idx;
    assign live_idx = IW'(aer_row) * IW'(COLS) + IW'(aer_col);

    p_ack_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(nrn_ack));

    p_ack_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (aer_valid && aer_ready) |=> ($countones(nrn_ack) == 1));

    p_ack_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (nrn_ack != '0) |-> $past(aer_valid && aer_ready));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (aer_valid && !aer_ready) |=> (aer_valid && $stable(aer_row) && $stable(aer_col)));

    p_no_repeat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (aer_valid && aer_ready) |=> !aer_valid);

    p_addr_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
        aer_valid |-> nrn_req[live_idx]);
endmodule

bind aer_token_encoder tre_check #(.ROWS(ROWS), .COLS(COLS)) u_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .nrn_req   (nrn_req),
    .nrn_ack   (nrn_ack),
    .aer_valid (aer_valid),
    .aer_ready (aer_ready),
    .aer_row   (aer_row),
    .aer_col   (aer_col)
);

// File: tb/aer_token_encoder_test.sv
module aer_token_encoder_test;
    localparam int CLK_PERIOD = 10;
    localparam int ROWS = 16;
    localparam int COLS = 16;
    localparam int NN = ROWS * COLS;

    logic          clk;
    logic          rst_n;
    logic [NN-1:0] req;
    logic [NN-1:0] ack;
    logic          aer_valid;
    logic          ready;
    logic [3:0]    aer_row;
    logic [3:0]    aer_col;

    aer_token_encoder #(.ROWS(ROWS), .COLS(COLS)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .nrn_req   (req),
        .nrn_ack   (ack),
        .aer_valid (aer_valid),
        .aer_ready (ready),
        .aer_row   (aer_row),
        .aer_col   (aer_col)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int total = 0, bad = 0, cyc = 0;
    bit hung = 0;
    int mrp = 0, mcp = 0;
    int exp_r [0:511];
    int exp_c [0:511];
    int n_exp = 0;
    int got_r [0:511];
    int got_c [0:511];
    int got_cyc [0:511];
    int n_got = 0;
    bit ack_due = 0;
    int ack_idx = 0;
    bit p_valid = 0, p_rdy = 0, last_valid = 0;
    int p_row = 0, p_col = 0;

    function automatic int first_one(input logic [NN-1:0] v);
        for (int i = 0; i < NN; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input bit rdy);
        @(negedge clk);
        cyc++;
        if (cyc > 190000) hung = 1;
        if (ack_due) begin
            check(ack == (NN'(1) << ack_idx) , "R8 ack pulse on sent neuron", first_one(ack), ack_idx);
            ack_due = 0;
        end else if (ack != '0) begin
            check(0, "R8 ack without transfer", first_one(ack), -1);
        end
        if (p_valid && !p_rdy)
            check(aer_valid && (int'(aer_row) == p_row) && (int'(aer_col) == p_col),
                  "R7 hold under backpressure",
                  int'(aer_valid) * 256 + int'(aer_row) * 16 + int'(aer_col),
                  256 + p_row * 16 + p_col);
        req   = req & ~ack;
        ready = rdy;
        last_valid = aer_valid;
        if (aer_valid && rdy) begin
            got_r[n_got]   = int'(aer_row);
            got_c[n_got]   = int'(aer_col);
            got_cyc[n_got] = cyc;
            n_got++;
            ack_due = 1;
            ack_idx = int'(aer_row) * COLS + int'(aer_col);
        end
        p_valid = aer_valid;
        p_rdy   = rdy;
        p_row   = int'(aer_row);
        p_col   = int'(aer_col);
    endtask

    // Expected send order from the requirements (R3, R5, R6, R9).
    task automatic build_order(input logic [NN-1:0] m);
        logic [NN-1:0]   rem;
        logic [COLS-1:0] snap;
        int rp, cp, c;
        rem = m; rp = mrp; cp = mcp; n_exp = 0;
        while (rem != '0) begin
            while (rem[rp*COLS +: COLS] == '0) rp = (rp + 1) % ROWS;
            snap = rem[rp*COLS +: COLS];
            c = cp;
            while (snap != '0) begin
                if (snap[c]) begin
                    exp_r[n_exp] = rp; exp_c[n_exp] = c; n_exp++;
                    snap[c] = 1'b0; rem[rp*COLS + c] = 1'b0; cp = c;
                end else begin
                    c = (c + 1) % COLS;
                end
            end
            rp = (rp + 1) % ROWS;
        end
        mrp = rp; mcp = cp;
    endtask

    task automatic single(input int idx);
        int r, c, expl, n0, lim;
        r = idx / COLS; c = idx % COLS;
        expl = ((r - mrp + ROWS) % ROWS) + ((c - mcp + COLS) % COLS) + 2;
        req[idx] = 1'b1;
        n0 = cyc; n_got = 0; lim = 0;
        do begin tick(1); lim++; end while (!last_valid && lim < 100 && !hung);
        check(cyc - n0 == expl, "R4 latency of lone request", cyc - n0, expl);
        check(n_got == 1 && got_r[0] == r && got_c[0] == c, "R2 address of lone request",
              got_r[0] * 16 + got_c[0], r * 16 + c);
        repeat (4) tick(1);
        mrp = (r + 1) % ROWS; mcp = c;
    endtask

    task automatic group(input logic [NN-1:0] m, input bit throttle, input string tag);
        int lim;
        build_order(m);
        req = req | m;
        n_got = 0; lim = 0;
        while ((n_got < n_exp) && lim < 20000 && !hung) begin
            tick(throttle ? ((cyc % 3) != 0) : 1'b1);
            lim++;
        end
        repeat (5) tick(1);
        check(n_got == n_exp, "R7 every request sent once", n_got, n_exp);
        for (int k = 0; k < n_exp && k < n_got; k++)
            check(got_r[k] == exp_r[k] && got_c[k] == exp_c[k], tag,
                  got_r[k] * 16 + got_c[k], exp_r[k] * 16 + exp_c[k]);
    endtask

    initial begin
        logic [NN-1:0] m;
        int r, x, y, z, lim;
        rst_n = 1'b0; req = '0; ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick(0);
        check(aer_valid == 1'b0, "R1 valid low after reset", int'(aer_valid), 0);
        check(ack == '0, "R1 no ack after reset", first_one(ack), -1);

        // R3: token stays put while idle; then full single sweep from (0,0)
        repeat (20) tick(1);
        for (int i = 0; i < NN && !hung; i++) single(i);
        for (int k = 0; k < 32 && !hung; k++) single((k * 149 + 7) % NN);

        // R5: column order within a row, with wrap, plus other rows
        m = '0;
        m[5*COLS + (mcp + 15) % COLS] = 1'b1;
        m[5*COLS + (mcp + 4) % COLS]  = 1'b1;
        m[5*COLS + (mcp + 9) % COLS]  = 1'b1;
        m[2*COLS + 7]  = 1'b1;
        m[12*COLS + 0] = 1'b1;
        group(m, 1'b0, "R5 column order in row");

        // R3: diagonal, one neuron per row, throttled ready
        m = '0;
        for (int i = 0; i < ROWS; i++) m[i*COLS + i] = 1'b1;
        group(m, 1'b1, "R3 row token order");

        // R6/R7: whole array under backpressure
        group('1, 1'b1, "R6 full array order");

        // R6: late arrival in a granted row waits for the next visit
        r = mrp; x = (mcp + 1) % COLS; y = (mcp + 5) % COLS; z = (mcp + 3) % COLS;
        req[r*COLS + x] = 1'b1;
        req[r*COLS + y] = 1'b1;
        n_got = 0; lim = 0;
        while (n_got < 1 && lim < 200 && !hung) begin tick(1); lim++; end
        req[r*COLS + z] = 1'b1;
        lim = 0;
        while (n_got < 3 && lim < 400 && !hung) begin tick(1); lim++; end
        repeat (5) tick(1);
        check(n_got == 3, "R6 late arrival count", n_got, 3);
        check(got_c[0] == x && got_c[1] == y && got_c[2] == z && got_r[2] == r,
              "R6 late arrival served after snapshot", got_c[2], z);
        check(got_cyc[2] - got_cyc[1] == 20 + ((z - y + COLS) % COLS),
              "R9 late arrival waits full row lap", got_cyc[2] - got_cyc[1],
              20 + ((z - y + COLS) % COLS));
        mrp = (r + 1) % ROWS; mcp = z;

        // R9: next lone request confirms token advanced past released row
        single(((mrp + 3) % ROWS) * COLS + (mcp + 2) % COLS);

        if (hung) check(0, "watchdog expired", cyc, 190000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule